// File: doc/BRIEF.md
# Masked Vector Byte Bit-Reverse Unit

This unit is the execution stage for a vector instruction that mirrors the bit order inside every byte of each element. It takes one source register image, the old contents of the destination register, a per-element mask and the vector controls. It returns a new destination image. Only bytes move their bits, and no bit crosses a byte boundary. For that reason the computed value of an element does not depend on the element width. The width still matters for three things: which bytes belong to an element, which mask bit governs them, and where the tail begins.

The caller presents the operands and pulses `start`. The unit latches everything and then visits one element per cycle, from the start index up to the effective vector length minus one. Each visited element gets one of three values: the reversed source, all ones, or its old value. The choice depends on the mask and the mask-agnostic flag. After the walk, a single cycle fills the tail. Then `done` pulses and the index output returns to zero, so the caller can clear its start-index register. If the length is zero, or the start index is not below it, the unit skips the walk and the tail fill and returns the old image untouched.

The controller has four states. IDLE waits for `start`. WALK writes one element per cycle. TAIL applies the tail policy. FIN raises `done`. The transitions are as follows:
- IDLE goes to WALK when start is accepted and the range is not empty.
- IDLE goes to FIN when start is accepted and the range is empty. This is the skip path.
- WALK goes to TAIL after the last element.
- TAIL always goes to FIN.
- FIN always goes back to IDLE.

Top module: `byte_bitrev_vunit`

## Requirements
- R1: In every written active element, output bit 8*b+k equals source bit 8*b+7-k, for each byte b and k in 0..7. The result is the same for every element width.
- R2: `width_code` selects the element size. A code of 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i covers bytes i*E to (i+1)*E-1 of the image, where E is the size in bytes. The element count T is VLEN/(8*E).
- R3: The unit writes elements from `vstart` to evl-1. Elements below `vstart` keep their old value. When the range is not empty, `done` is high exactly evl-vstart+2 cycles after the edge that accepts `start`.
- R4: When evl is 0 or `vstart` >= evl, `dst_img` equals `old_img` in full, `done` is high in the cycle after acceptance, and `busy` never rises.
- R5: When `all_active` is 0 and `elem_mask[i]` is 0, element i is not computed. It becomes all ones if `mask_agn` is 1 and keeps its old value otherwise. When `all_active` is 1, the mask is ignored.
- R6: Elements from evl up to T-1 become all ones when `tail_agn` is 1 and keep their old value otherwise.
- R7: `busy` is high throughout the walk and tail fill, and `done` is a one-cycle pulse. `busy` and `done` are never high together. A `start` pulse while `busy` is high has no effect on the result.
- R8: `cur_index` is 0 whenever `done` is high.
- R9: A synchronous active-low reset clears `busy`, `done` and `cur_index` by the next clock edge, even in the middle of a walk.
- R10: The effective length evl is min(`vl`, T). A `vl` above T behaves like `vl` = T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (sampled when idle) |
| width_code | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| vl | input | CNTW | Vector length in elements |
| vstart | input | CNTW | First element index to process |
| all_active | input | 1 | 1: every element computed; 0: `elem_mask` governs |
| tail_agn | input | 1 | Tail elements filled with ones when 1 |
| mask_agn | input | 1 | Masked-off elements filled with ones when 1 |
| elem_mask | input | VLEN/8 | One bit per element index |
| src_img | input | VLEN | Source register image |
| old_img | input | VLEN | Previous destination register image |
| busy | output | 1 | Walk or tail fill in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_index | output | CNTW | Element being processed; 0 once finished |
| dst_img | output | VLEN | Resulting destination image, held after done |

## Verification
The bench sweeps all four widths, every length from zero to one past the element count, and start indices at 0, 1, vl-1 and vl. Each combination runs with all eight settings of the mask-enable and the two agnostic flags, and a model of the policy computes the expected image.

The sweep targets several specific faults:
- A design that derives byte ownership from the wrong width would scramble which mask bit governs which byte.
- A design that writes from index 0 would corrupt the prefix below the start index.
- A design that runs the tail fill on the skip path would wreck the image when vstart equals vl.
- A design that does not clamp an oversized vl would walk past the register.

Latency is checked per case, which exposes off-by-one loop ends. A second start in mid-walk and a reset in mid-walk check that the latched operands are held and that the control state clears.

// File: rtl/brv_pkg.sv
package brv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_TAIL = 2'd2,
        ST_FIN  = 2'd3
    } brv_state_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } brv_ew_e;

    typedef struct packed {
        logic    all_active;
        logic    tail_agn;
        logic    mask_agn;
        brv_ew_e ew;
    } brv_ctl_t;

endpackage

// File: rtl/brv_byte_rev.sv
// Mirrors the bit order inside every byte of a wide word.
module brv_byte_rev #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] din,
    output logic [NBYTES*8-1:0] dout
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign dout[b*8 + k] = din[b*8 + 7 - k];
        end
    end
endmodule

// File: rtl/brv_lane_sel.sv
// Per-byte ownership: which bytes belong to the current element, and
// which bytes lie at or beyond the effective length.
module brv_lane_sel #(
    parameter int NBYTES = 16,
    parameter int CNTW   = 5
) (
    input  brv_pkg::brv_ew_e  ew,
    input  logic [CNTW-1:0]   idx,
    input  logic [CNTW-1:0]   evl,
    output logic [NBYTES-1:0] elem_hit,
    output logic [NBYTES-1:0] tail_hit
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [CNTW-1:0] owner;
        assign owner       = CNTW'(b) >> ew;
        assign elem_hit[b] = (owner == idx);
        assign tail_hit[b] = (owner >= evl);
    end
endmodule

// File: rtl/brv_ctrl.sv
// Sequencer: IDLE -> WALK -> TAIL -> FIN -> IDLE, or IDLE -> FIN on skip.
module brv_ctrl
    import brv_pkg::*;
#(
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CNTW-1:0] vs_in,
    input  logic [CNTW-1:0] evl_in,
    output brv_state_e      state_o,
    output logic [CNTW-1:0] idx_o,
    output logic [CNTW-1:0] evl_o,
    output logic            accept,
    output logic            busy,
    output logic            done,
    output logic            walk_en,
    output logic            tail_en
);
    brv_state_e      state_q, state_d;
    logic [CNTW-1:0] idx_q, evl_q;
    logic            skip, last;

    assign skip = (evl_in == '0) || (vs_in >= evl_in);
    assign last = (idx_q == evl_q - CNTW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = skip ? ST_FIN : ST_WALK;
            ST_WALK: if (last)  state_d = ST_TAIL;
            ST_TAIL: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    // element index and latched length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            evl_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q <= skip ? '0 : vs_in;
                    evl_q <= evl_in;
                end
                ST_WALK: if (!last) idx_q <= idx_q + CNTW'(1);
                ST_TAIL: idx_q <= '0;
                ST_FIN:  idx_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        busy    = (state_q == ST_WALK) || (state_q == ST_TAIL);
        done    = (state_q == ST_FIN);
        walk_en = (state_q == ST_WALK);
        tail_en = (state_q == ST_TAIL);
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign evl_o   = evl_q;
endmodule

// File: rtl/byte_bitrev_vunit.sv
module byte_bitrev_vunit
    import brv_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int NBYTES = VLEN / 8,
    localparam int CNTW   = $clog2(NBYTES + 1),
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        width_code,
    input  logic [CNTW-1:0]   vl,
    input  logic [CNTW-1:0]   vstart,
    input  logic              all_active,
    input  logic              tail_agn,
    input  logic              mask_agn,
    input  logic [NBYTES-1:0] elem_mask,
    input  logic [VLEN-1:0]   src_img,
    input  logic [VLEN-1:0]   old_img,
    output logic              busy,
    output logic              done,
    output logic [CNTW-1:0]   cur_index,
    output logic [VLEN-1:0]   dst_img
);
    brv_ctl_t          ctl_q;
    logic [VLEN-1:0]   src_q, dst_q, rev_w, dst_d;
    logic [NBYTES-1:0] mask_q, elem_hit, tail_hit;
    logic [CNTW-1:0]   total_in, evl_in, idx, evl;
    logic              accept, walk_en, tail_en, elem_on;
    brv_state_e        state;

    // effective length: clamp to element count of the requested width
    assign total_in = CNTW'(NBYTES) >> width_code;
    assign evl_in   = (vl > total_in) ? total_in : vl;

    brv_ctrl #(.CNTW(CNTW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .vs_in(vstart), .evl_in(evl_in),
        .state_o(state), .idx_o(idx), .evl_o(evl),
        .accept(accept), .busy(busy), .done(done),
        .walk_en(walk_en), .tail_en(tail_en)
    );

    brv_byte_rev #(.NBYTES(NBYTES)) u_rev (.din(src_q), .dout(rev_w));

    brv_lane_sel #(.NBYTES(NBYTES), .CNTW(CNTW)) u_sel (
        .ew(ctl_q.ew), .idx(idx), .evl(evl),
        .elem_hit(elem_hit), .tail_hit(tail_hit)
    );

    assign elem_on = ctl_q.all_active || mask_q[idx[IW-1:0]];

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        always_comb begin
            dst_d[b*8 +: 8] = dst_q[b*8 +: 8];
            if (walk_en && elem_hit[b]) begin
                if (elem_on)             dst_d[b*8 +: 8] = rev_w[b*8 +: 8];
                else if (ctl_q.mask_agn) dst_d[b*8 +: 8] = 8'hFF;
            end else if (tail_en && tail_hit[b] && ctl_q.tail_agn) begin
                dst_d[b*8 +: 8] = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            mask_q <= '0;
        end else if (accept) begin
            ctl_q  <= '{all_active: all_active, tail_agn: tail_agn,
                        mask_agn: mask_agn, ew: brv_ew_e'(width_code)};
            src_q  <= src_img;
            dst_q  <= old_img;
            mask_q <= elem_mask;
        end else begin
            dst_q  <= dst_d;
        end
    end

    assign cur_index = idx;
    assign dst_img   = dst_q;

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/brv_checker.sv
module brv_checker #(
    parameter int VLEN = 128,
    localparam int NBYTES = VLEN / 8,
    localparam int CNTW   = $clog2(NBYTES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [CNTW-1:0] vl,
    input logic            busy,
    input logic            done,
    input logic [CNTW-1:0] cur_index,
    input logic [VLEN-1:0] dst_img
);
    // R7: busy and done never overlap
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: index back at zero at completion
    p_index_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_index == '0));

    // R4: zero length completes on the next cycle
    p_skip_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && (vl == '0)) |=> (done && !busy));

    // R3: image is held while idle
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(dst_img));

    // R9: reset clears the control outputs
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && (cur_index == '0)));
endmodule

bind byte_bitrev_vunit brv_checker #(.VLEN(VLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .busy(busy), .done(done), .cur_index(cur_index), .dst_img(dst_img)
);

// File: tb/sim_byte_bitrev_vunit.sv
module sim_byte_bitrev_vunit;
    localparam int VLEN = 128;
    localparam int NB   = VLEN / 8;
    localparam int CW   = $clog2(NB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      width_code = '0;
    logic [CW-1:0]   vl = '0, vstart = '0;
    logic            all_active = 1'b1, tail_agn = 1'b0, mask_agn = 1'b0;
    logic [NB-1:0]   elem_mask = '0;
    logic [VLEN-1:0] src_img = '0, old_img = '0;
    logic            busy, done;
    logic [CW-1:0]   cur_index;
    logic [VLEN-1:0] dst_img;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    byte_bitrev_vunit #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
        .vl(vl), .vstart(vstart), .all_active(all_active),
        .tail_agn(tail_agn), .mask_agn(mask_agn), .elem_mask(elem_mask),
        .src_img(src_img), .old_img(old_img),
        .busy(busy), .done(done), .cur_index(cur_index), .dst_img(dst_img)
    );

    function automatic logic [VLEN-1:0] rand_img();
        logic [VLEN-1:0] r;
        for (int i = 0; i < VLEN / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [VLEN-1:0] model(
        logic [VLEN-1:0] s, logic [VLEN-1:0] o, logic [NB-1:0] m,
        int w, int l, int vs, bit aa, bit ta, bit ma);
        logic [VLEN-1:0] r = o;
        int t   = NB >> w;
        int evl = (l > t) ? t : l;
        if (evl == 0 || vs >= evl) return o;
        for (int b = 0; b < NB; b++) begin
            logic [7:0] rv;
            int e = b >> w;
            for (int k = 0; k < 8; k++) rv[k] = s[b*8 + 7 - k];
            if (e < vs) begin
            end else if (e < evl) begin
                if (aa || m[e]) r[b*8 +: 8] = rv;
                else if (ma)    r[b*8 +: 8] = 8'hFF;
            end else if (ta) begin
                r[b*8 +: 8] = 8'hFF;
            end
        end
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One operation; poke injects a second start during the walk (R7)
    task automatic run_case(int w, int l, int vs, bit aa, bit ta, bit ma, bit poke);
        logic [VLEN-1:0] s = rand_img();
        logic [VLEN-1:0] o = rand_img();
        logic [NB-1:0]   m = NB'($urandom);
        logic [VLEN-1:0] exp;
        int t   = NB >> w;
        int evl = (l > t) ? t : l;
        bit sk  = (evl == 0 || vs >= evl);
        int lat = sk ? 1 : (evl - vs + 2);
        int n   = 0;
        bit saw_busy = 0;
        exp = model(s, o, m, w, l, vs, aa, ta, ma);
        @(negedge clk);
        width_code = 2'(w); vl = CW'(l); vstart = CW'(vs);
        all_active = aa; tail_agn = ta; mask_agn = ma;
        elem_mask = m; src_img = s; old_img = o; start = 1'b1;
        @(posedge clk);
        while (n < 40) begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (done) break;
            if (busy) saw_busy = 1;
            if (poke && n == 2) begin
                start = 1'b1; src_img = ~s; old_img = ~o;
                elem_mask = ~m; vl = CW'(1); vstart = '0;
            end
        end
        start = 1'b0;
        chk(n == lat, $sformatf("R3 R4 latency w=%0d vl=%0d vs=%0d", w, l, vs),
            VLEN'(n), VLEN'(lat));
        chk(dst_img === exp,
            $sformatf("R1 R2 R3 R5 R6 R10 image w=%0d vl=%0d vs=%0d aa=%0d ta=%0d ma=%0d poke=%0d R7",
                      w, l, vs, aa, ta, ma, poke), dst_img, exp);
        chk(cur_index == '0, "R8 index cleared", VLEN'(cur_index), '0);
        if (sk) chk(!saw_busy, "R4 busy on skip", VLEN'(saw_busy), '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && cur_index == '0, "R9 reset state",
            VLEN'({busy, done, cur_index}), '0);
        rst_n = 1'b1;

        for (int w = 0; w < 4; w++) begin
            for (int l = 0; l <= (NB >> w) + 1; l++) begin
                for (int vi = 0; vi < 4; vi++) begin
                    int vs = (vi == 0) ? 0 : (vi == 1) ? 1 : (vi == 2) ? ((l > 0) ? l - 1 : 0) : l;
                    for (int f = 0; f < 8; f++)
                        run_case(w, l, vs, f[0], f[1], f[2], 1'b0);
                end
            end
        end

        // R7: start while busy is ignored
        for (int w = 0; w < 4; w++) begin
            run_case(w, NB >> w, 0, 1'b0, 1'b1, 1'b1, 1'b1);
            run_case(w, NB >> w, 1, 1'b1, 1'b0, 1'b0, 1'b1);
        end

        // R9: reset in the middle of a walk
        @(negedge clk);
        width_code = 2'd0; vl = CW'(NB); vstart = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy, "R7 busy mid-walk", VLEN'(busy), VLEN'(1));
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && cur_index == '0, "R9 reset mid-walk",
            VLEN'({busy, done, cur_index}), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R9 stays idle after reset", VLEN'({busy, done}), '0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule